// File: doc/BRIEF.md
# XOR Phase-Duty Lock Monitor

This block decides whether a phase-locked loop is locked by looking at two clocks that have already been divided down to the compare rate: the reference and the fed-back oscillator. Both are brought into a fast sampling clock domain. Their exclusive-OR is high for the part of each compare period in which the two disagree, so the fraction of sampled-high cycles is a direct measure of their phase difference. Counting those cycles over a window whose length is programmable gives one phase sample. Full duty maps to 180 degrees and zero duty maps to 0 degrees. A first-order shift-based IIR then smooths successive samples, which does the job a low-pass capacitor would do in an analog monitor.

The smoothed estimate is driven out as `phase_est`. After each filter update it is compared with a programmable threshold in degrees. When the estimate is strictly above the threshold, the active-low `lol_n` output drops. When the two clocks run at the same frequency with little offset, the XOR duty stays small and `lol_n` stays high. When their frequencies differ, the phase slips continuously, the duty averages near one half (about 90 degrees), and `lol_n` goes low for any threshold below that. As a rule of thumb, the window and the filter time constant together should give a corner about ten times below the beat frequency the monitor has to catch.

A three-state machine drives `lol_n`. The states are WARMUP, IN_LOCK and OUT_OF_LOCK:
- WARMUP is entered on reset.
- WARMUP goes to IN_LOCK on the first filter update with the estimate at or below the threshold, and to OUT_OF_LOCK on the first filter update with the estimate above it.
- IN_LOCK goes to OUT_OF_LOCK on an update whose estimate exceeds the threshold.
- OUT_OF_LOCK goes back to IN_LOCK on an update whose estimate is at or below the threshold.
- Any other cycle holds the state.

Only IN_LOCK drives `lol_n` high.

Top module: `lock_monitor`

## Requirements
- R1: While reset is asserted and after its release, `lol_n` is 0 and `phase_est` is 0 until the first filter update.
- R2: Each input passes through two flops in the sampling domain before the XOR. A window lasts 2^`win_sel` sampling cycles. A `win_sel` value above WIN_LOG2_MAX (default 12) is treated as WIN_LOG2_MAX. The window length is taken from `win_sel` at the first sample of each window, and windows follow one another without gaps starting at reset release.
- R3: A window that counts c high samples over 2^w cycles yields floor(c*180/2^w) degrees. Full duty gives 180 and zero duty gives 0.
- R4: The filter state is A and the estimate is floor(A/2^K), with K = FILT_SHIFT (default 3). The first window result after reset loads A = result*2^K. Each later result r sets A to A - floor(A/2^K) + r. The update lands one cycle after the window ends, and `phase_est` always shows the estimate.
- R5: One cycle after each filter update, `lol_n` is 0 if the new estimate is strictly greater than the threshold, and 1 if it is less than or equal to it. An estimate exactly equal to the threshold counts as locked.
- R6: A `thresh_deg` above 180 acts as 180. An estimate can therefore never exceed it, and even antiphase clocks read as locked.
- R7: From reset until the first filter update, `lol_n` stays 0 whatever the inputs are.
- R8: `lol_n` changes only in the cycle after a filter update. A change of `thresh_deg` between updates has no effect until the next update.
- R9: Equal-frequency in-phase clocks give an estimate of 0 and a high `lol_n`. Clocks of different frequency give an estimate near 90 and a low `lol_n` against a 45-degree threshold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_in | input | 1 | Prescaled reference compare clock (asynchronous) |
| fb_in | input | 1 | Prescaled oscillator compare clock (asynchronous) |
| thresh_deg | input | 8 | Out-of-lock threshold in degrees, 0 to 180 |
| win_sel | input | $clog2(WIN_LOG2_MAX+1) | Log2 of the averaging window length |
| lol_n | output | 1 | 1 = locked, 0 = out of lock or warming up |
| phase_est | output | 8 | Filtered phase difference in degrees |

## Verification
The hardest situation to reach from the ports is a threshold change landing strictly between two filter updates. Its effect has to be deferred, and nothing at the ports marks the update instants directly. The stimulus therefore resets the block with a long window, so that update times are known from the reset release. It then changes the threshold in the middle of a window and samples `lol_n` both before and after the next boundary. The saturating threshold, the clamp on the window selector and the exact-equality boundary at 45 degrees all use periodic patterns whose XOR duty is a whole number of degrees over any aligned window. A behavioural model tracks every cycle in parallel.

// File: rtl/lock_mon_pkg.sv
package lock_mon_pkg;
    localparam int DEG_W    = 8;
    localparam int DEG_FULL = 180;

    typedef enum logic [1:0] {
        ST_WARMUP      = 2'd0,
        ST_IN_LOCK     = 2'd1,
        ST_OUT_OF_LOCK = 2'd2
    } lm_state_e;
endpackage

// File: rtl/lm_sync2.sv
module lm_sync2 #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] d,
    output logic [N-1:0] q
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        logic s1_q, s2_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                s1_q <= 1'b0;
                s2_q <= 1'b0;
            end else begin
                s1_q <= d[i];
                s2_q <= s1_q;
            end
        end
        assign q[i] = s2_q;
    end
endmodule

// File: rtl/lm_xor_window.sv
module lm_xor_window
    import lock_mon_pkg::*;
#(
    parameter  int WMAX  = 12,
    localparam int SEL_W = $clog2(WMAX + 1),
    localparam int CW    = WMAX + 1,
    localparam int PW    = CW + DEG_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             x_bit,
    input  logic [SEL_W-1:0] win_sel,
    output logic             res_vld,
    output logic [DEG_W-1:0] res_deg
);
    logic [SEL_W-1:0] sel_c, len_q, eff;
    logic [WMAX-1:0]  pos_q;
    logic [CW-1:0]    ones_q, sum, lim;
    logic [PW-1:0]    prod;
    logic             last;

    always_comb begin
        sel_c = (win_sel > SEL_W'(WMAX)) ? SEL_W'(WMAX) : win_sel;
        eff   = (pos_q == '0) ? sel_c : len_q;
        lim   = (CW'(1) << eff) - CW'(1);
        last  = ({1'b0, pos_q} == lim);
        sum   = ones_q + CW'(x_bit);
        prod  = (PW'(sum) * PW'(DEG_FULL)) >> eff;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pos_q   <= '0;
            ones_q  <= '0;
            len_q   <= '0;
            res_vld <= 1'b0;
            res_deg <= '0;
        end else begin
            res_vld <= last;
            if (pos_q == '0) begin
                len_q <= sel_c;
            end
            if (last) begin
                pos_q   <= '0;
                ones_q  <= '0;
                res_deg <= prod[DEG_W-1:0];
            end else begin
                pos_q  <= pos_q + WMAX'(1);
                ones_q <= sum;
            end
        end
    end

    // R3: a window result never exceeds the full-duty angle
    a_r3_deg_bound: assert property (@(posedge clk) disable iff (!rst_n)
        res_vld |-> (res_deg <= DEG_W'(DEG_FULL)));
endmodule

// File: rtl/lm_iir.sv
module lm_iir
    import lock_mon_pkg::*;
#(
    parameter  int K  = 3,
    localparam int AW = DEG_W + K + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_vld,
    input  logic [DEG_W-1:0] in_deg,
    output logic             out_vld,
    output logic [DEG_W-1:0] est
);
    logic [AW-1:0] acc_q;
    logic          first_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q   <= '0;
            first_q <= 1'b1;
            out_vld <= 1'b0;
        end else begin
            out_vld <= in_vld;
            if (in_vld) begin
                if (first_q) begin
                    acc_q   <= AW'(in_deg) << K;
                    first_q <= 1'b0;
                end else begin
                    acc_q <= acc_q - (acc_q >> K) + AW'(in_deg);
                end
            end
        end
    end

    assign est = DEG_W'(acc_q >> K);

    // R4: the filter only moves the cycle after a window result
    a_r4_update_follows_window: assert property (@(posedge clk) disable iff (!rst_n)
        out_vld |-> $past(in_vld));
    // R4: the smoothed estimate stays inside the angle range
    a_r4_est_bound: assert property (@(posedge clk) disable iff (!rst_n)
        est <= DEG_W'(DEG_FULL));
endmodule

// File: rtl/lock_monitor.sv
module lock_monitor
    import lock_mon_pkg::*;
#(
    parameter  int WIN_LOG2_MAX = 12,
    parameter  int FILT_SHIFT   = 3,
    localparam int SEL_W        = $clog2(WIN_LOG2_MAX + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_in,
    input  logic             fb_in,
    input  logic [7:0]       thresh_deg,
    input  logic [SEL_W-1:0] win_sel,
    output logic             lol_n,
    output logic [7:0]       phase_est
);
    logic [1:0]       synced;
    logic             x_bit;
    logic             win_vld;
    logic [DEG_W-1:0] win_deg;
    logic             upd;
    logic [DEG_W-1:0] est;
    logic [DEG_W-1:0] thr_c;
    logic             over;
    lm_state_e        state_q, state_d;
    logic             seen_q;

    lm_sync2 #(.N(2)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({fb_in, ref_in}),
        .q     (synced)
    );

    assign x_bit = synced[0] ^ synced[1];

    lm_xor_window #(.WMAX(WIN_LOG2_MAX)) u_win (
        .clk     (clk),
        .rst_n   (rst_n),
        .x_bit   (x_bit),
        .win_sel (win_sel),
        .res_vld (win_vld),
        .res_deg (win_deg)
    );

    lm_iir #(.K(FILT_SHIFT)) u_filt (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_vld  (win_vld),
        .in_deg  (win_deg),
        .out_vld (upd),
        .est     (est)
    );

    always_comb begin
        thr_c = (thresh_deg > 8'(DEG_FULL)) ? 8'(DEG_FULL) : thresh_deg;
        over  = (est > thr_c);
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_WARMUP:      if (upd) state_d = over ? ST_OUT_OF_LOCK : ST_IN_LOCK;
            ST_IN_LOCK:     if (upd && over) state_d = ST_OUT_OF_LOCK;
            ST_OUT_OF_LOCK: if (upd && !over) state_d = ST_IN_LOCK;
            default:        state_d = ST_WARMUP;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_WARMUP;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        lol_n     = (state_q == ST_IN_LOCK);
        phase_est = est;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen_q <= 1'b0;
        end else if (upd) begin
            seen_q <= 1'b1;
        end
    end

    // R5: an estimate above the threshold drops the output next cycle
    a_r5_over_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (upd && over) |=> !lol_n);
    // R5: an estimate at or below the threshold raises the output next cycle
    a_r5_under_raises: assert property (@(posedge clk) disable iff (!rst_n)
        (upd && !over) |=> lol_n);
    // R8: no change of the output without an update
    a_r8_hold_between_updates: assert property (@(posedge clk) disable iff (!rst_n)
        !upd |=> $stable(lol_n));
    // R7: the output stays low until the first estimate exists
    a_r7_low_during_warmup: assert property (@(posedge clk) disable iff (!rst_n)
        !seen_q |-> !lol_n);
endmodule

// File: tb/tb_lock_monitor.sv
module tb_lock_monitor;
    localparam int WMAX = 12;
    localparam int K    = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ref_in = 1'b0;
    logic       fb_in = 1'b0;
    logic [7:0] thresh_deg = 8'd45;
    logic [3:0] win_sel = 4'd4;
    logic       lol_n;
    logic [7:0] phase_est;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    int pr = 8, pf = 8, ro = 0, fo = 0;
    int tick = 0;

    always #10 clk = ~clk;

    lock_monitor dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .ref_in     (ref_in),
        .fb_in      (fb_in),
        .thresh_deg (thresh_deg),
        .win_sel    (win_sel),
        .lol_n      (lol_n),
        .phase_est  (phase_est)
    );

    // stimulus clocks, changed mid-cycle
    always @(posedge clk) begin
        #5;
        tick++;
        ref_in = (((tick + ro) % pr) < pr / 2);
        fb_in  = (((tick + fo) % pf) < pf / 2);
    end

    // behavioural reference model
    bit dq_r[$];
    bit dq_f[$];
    int m_pos, m_ones, m_len, m_log, m_wv, m_wdeg, m_acc, m_first, m_fv, m_state;
    int xv, sel, mthr;

    always @(posedge clk) begin
        if (!rst_n) begin
            dq_r.delete(); dq_f.delete();
            m_pos = 0; m_ones = 0; m_len = 1; m_log = 0; m_wv = 0; m_wdeg = 0;
            m_acc = 0; m_first = 1; m_fv = 0; m_state = 0;
        end else begin
            mthr = (thresh_deg > 180) ? 180 : int'(thresh_deg);
            if (m_fv != 0) m_state = ((m_acc >> K) > mthr) ? 2 : 1;
            if (m_wv != 0) begin
                if (m_first != 0) begin
                    m_acc = m_wdeg << K;
                    m_first = 0;
                end else begin
                    m_acc = m_acc - (m_acc >> K) + m_wdeg;
                end
                m_fv = 1;
            end else begin
                m_fv = 0;
            end
            xv = (dq_r.size() == 2) ? int'(dq_r[0] ^ dq_f[0]) : 0;
            if (m_pos == 0) begin
                sel = (win_sel > WMAX) ? WMAX : int'(win_sel);
                m_log = sel;
                m_len = 1 << sel;
            end
            m_ones += xv;
            m_pos++;
            if (m_pos == m_len) begin
                m_wdeg = (m_ones * 180) >> m_log;
                m_wv = 1;
                m_ones = 0;
                m_pos = 0;
            end else begin
                m_wv = 0;
            end
            if (dq_r.size() == 2) begin
                void'(dq_r.pop_front());
                void'(dq_f.pop_front());
            end
            dq_r.push_back(ref_in);
            dq_f.push_back(fb_in);
        end
    end

    // cycle-by-cycle comparison away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            checks++;
            if (lol_n !== (m_state == 1)) begin
                failures++;
                $display("FAIL R5 R8 lol_n actual=%0d expected=%0d t=%0t", lol_n, (m_state == 1), $time);
            end
            checks++;
            if (int'(phase_est) != (m_acc >> K)) begin
                failures++;
                $display("FAIL R4 phase_est actual=%0d expected=%0d t=%0t", phase_est, m_acc >> K, $time);
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            done = 1;
            failures++;
            $display("FAIL watchdog expired before the sequence ended");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        wait_cyc(3);
        chk(lol_n == 1'b0, "R1 lol_n in reset", lol_n, 0);
        rst_n = 1'b1;
        wait_cyc(3);
        chk(lol_n == 1'b0, "R1 lol_n after reset", lol_n, 0);
        chk(phase_est == 8'd0, "R1 phase_est after reset", phase_est, 0);
        wait_cyc(9);
        chk(lol_n == 1'b0, "R7 low before first update", lol_n, 0);

        wait_cyc(2000);
        chk(phase_est == 8'd0, "R9 in-phase estimate", phase_est, 0);
        chk(lol_n == 1'b1, "R9 in-phase locked", lol_n, 1);

        ro = 4;
        wait_cyc(3000);
        chk(phase_est == 8'd180, "R3 full duty angle", phase_est, 180);
        chk(lol_n == 1'b0, "R5 antiphase out of lock", lol_n, 0);

        ro = 1;
        wait_cyc(3000);
        chk(phase_est == 8'd45, "R3 quarter duty angle", phase_est, 45);
        chk(lol_n == 1'b1, "R5 equal to threshold is locked", lol_n, 1);

        thresh_deg = 8'd44;
        wait_cyc(200);
        chk(lol_n == 1'b0, "R5 one below estimate drops", lol_n, 0);

        thresh_deg = 8'd200;
        ro = 4;
        wait_cyc(3000);
        chk(phase_est == 8'd180, "R6 antiphase estimate", phase_est, 180);
        chk(lol_n == 1'b1, "R6 saturated threshold locked", lol_n, 1);

        thresh_deg = 8'd45;
        ro = 0;
        pf = 10;
        win_sel = 4'd6;
        wait_cyc(4000);
        chk(phase_est > 8'd45, "R9 mismatch estimate above 45", phase_est, 46);
        chk(lol_n == 1'b0, "R9 frequency mismatch out of lock", lol_n, 0);

        pf = 8;
        win_sel = 4'd15;
        do_reset();
        wait_cyc(4000);
        chk(lol_n == 1'b0, "R2 clamped window not yet done", lol_n, 0);
        wait_cyc(200);
        chk(lol_n == 1'b1, "R2 clamped window of 4096 done", lol_n, 1);

        win_sel = 4'd8;
        ro = 1;
        thresh_deg = 8'd45;
        do_reset();
        wait_cyc(300);
        chk(lol_n == 1'b1, "R8 locked after first update", lol_n, 1);
        thresh_deg = 8'd0;
        wait_cyc(100);
        chk(lol_n == 1'b1, "R8 threshold change deferred", lol_n, 1);
        wait_cyc(200);
        chk(lol_n == 1'b0, "R8 threshold applied at next update", lol_n, 0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule